// File: doc/BRIEF.md
# Operand Bypass Selector

This combinational block picks the value of one source operand while an instruction sits in the register-file stage of an in-order pipeline. Three candidates arrive together: the register-file read data, the result the ALU stage is computing this cycle, and the value being written back to the register file this cycle. The selector looks at the register-stage opcode and source register number, and at the destination register and opcode of the ALU stage. It also looks at the write-back enable and write address. From these it chooses which candidate becomes the operand.

The register file is read combinationally and written on the clock edge at the end of the pipe. A result being written back in the same cycle is therefore not yet visible at the array's read port, so the write-back path must be forwarded too. Register 31 is hard-wired to zero and is never forwarded. A newer result in the ALU stage wins over an older result at write-back.

One copy of the block serves each source operand. The parameter `SRC_SEL` picks the variant: 0 for the first source operand (A) and 1 for the second (B). The decision is made by a small selection state: RF_PATH (no forwarding), ALU_PATH (ALU-stage forward) and WB_PATH (write-back forward). These are evaluated every cycle with no stored history. Each cycle moves from any of the three states to any other according to the hit conditions below.

Top module: `operand_bypass_sel`

## Requirements
- R1: When no forwarding condition holds, `opnd_out` equals `rf_rdata`.
- R2: Opcode class is `op[5:4]`: 2'b10 is register-register ALU, 2'b11 is ALU-with-constant, 2'b01 is memory/control, 2'b00 reads no source. In class 2'b01, low nibbles 4'h0 (load), 4'h1 (store), 4'h3 (jump), 4'h4 (branch-if-zero) and 4'h5 (branch-if-nonzero) read operand A; every other low nibble reads nothing.
- R3: Operand A is read by classes 2'b10, 2'b11 and the listed class-2'b01 opcodes. Operand B is read only by class 2'b10. An instruction that does not read the operand never gets a forwarded value.
- R4: ALU forward (`opnd_out` = `alu_result`): the operand is read, `alu_valid`=1, the ALU-stage opcode class is 2'b10 or 2'b11, `rf_src` equals `alu_dest`, and `rf_src` is not 31.
- R5: Write-back forward (`opnd_out` = `wb_data`): the operand is read, `rf_src` is not 31, the ALU forward does not apply, `wb_we`=1, and `rf_src` equals `wb_addr`.
- R6: When both forwards match, the ALU-stage result is chosen.
- R7: When `rf_src` is 31, the output is always `rf_rdata`.
- R8: When `alu_valid`=0 (annulled instruction or bubble), the ALU stage is ignored and the write-back rule alone decides.
- R9: An ALU stage holding a class 2'b00 or 2'b01 opcode is never forwarded from, even when its `alu_dest` matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rf_op | input | 6 | Opcode of the instruction in the register-file stage |
| rf_src | input | 5 | Source register number for this operand |
| alu_op | input | 6 | Opcode of the instruction in the ALU stage |
| alu_dest | input | 5 | Destination register of the ALU-stage instruction |
| alu_valid | input | 1 | ALU stage holds a live instruction (0 = annulled or bubble) |
| wb_we | input | 1 | Register-file write enable at write-back |
| wb_addr | input | 5 | Register-file write address at write-back |
| rf_rdata | input | 32 | Data read from the register file array |
| alu_result | input | 32 | Result produced by the ALU stage this cycle |
| wb_data | input | 32 | Data being written back this cycle |
| opnd_out | output | 32 | Selected operand |

## Verification
The assertions assume the opcode fields follow the class encoding of R2. They also assume the three data candidates may coincide, so a check on equality with one candidate only means something where the other candidates differ. The stimulus draws register numbers from a small pool that includes 31, which makes matches between source, ALU destination and write address frequent. Data values are drawn independently, so the candidates differ with high probability. Directed cases set the candidates to distinct constants so that each forwarding path, the priority and the zero-register exclusion can be told apart at the output.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int REG_AW   = 5;
    localparam int DATA_W   = 32;
    localparam int OP_W     = 6;
    localparam int ZERO_REG = (1 << REG_AW) - 1;

    typedef enum logic [1:0] {
        CL_NONE   = 2'b00,
        CL_MEMCTL = 2'b01,
        CL_ALU_RR = 2'b10,
        CL_ALU_RC = 2'b11
    } op_class_t;

    typedef enum logic [1:0] {
        RF_PATH  = 2'd0,
        ALU_PATH = 2'd1,
        WB_PATH  = 2'd2
    } path_t;

    function automatic op_class_t class_of(input logic [OP_W-1:0] op);
        return op_class_t'(op[OP_W-1:OP_W-2]);
    endfunction

endpackage

// File: rtl/bypass_src_decode.sv
module bypass_src_decode
    import bypass_pkg::*;
#(
    parameter int SRC_SEL = 0
) (
    input  logic [OP_W-1:0] op,
    output logic            reads_src
);

    op_class_t cls;
    logic      memctl_reads;

    assign cls = class_of(op);

    always_comb begin
        unique case (op[3:0])
            4'h0, 4'h1, 4'h3, 4'h4, 4'h5: memctl_reads = 1'b1;
            default:                      memctl_reads = 1'b0;
        endcase
    end

    generate
        if (SRC_SEL == 0) begin : g_src_a
            always_comb begin
                unique case (cls)
                    CL_ALU_RR, CL_ALU_RC: reads_src = 1'b1;
                    CL_MEMCTL:            reads_src = memctl_reads;
                    default:              reads_src = 1'b0;
                endcase
            end
        end else begin : g_src_b
            always_comb begin
                unique case (cls)
                    CL_ALU_RR: reads_src = 1'b1;
                    default:   reads_src = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/bypass_path_select.sv
module bypass_path_select
    import bypass_pkg::*;
(
    input  logic              reads_src,
    input  logic [REG_AW-1:0] rf_src,
    input  logic [OP_W-1:0]   alu_op,
    input  logic [REG_AW-1:0] alu_dest,
    input  logic              alu_valid,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_addr,
    output path_t             path
);

    logic src_live;
    logic alu_writes;
    logic alu_hit;
    logic wb_hit;

    assign src_live = reads_src && (rf_src != REG_AW'(ZERO_REG));

    always_comb begin
        unique case (class_of(alu_op))
            CL_ALU_RR, CL_ALU_RC: alu_writes = alu_valid;
            default:              alu_writes = 1'b0;
        endcase
    end

    assign alu_hit = src_live && alu_writes && (rf_src == alu_dest);
    assign wb_hit  = src_live && wb_we && (rf_src == wb_addr);

    always_comb begin
        if (alu_hit)     path = ALU_PATH;
        else if (wb_hit) path = WB_PATH;
        else             path = RF_PATH;
    end

endmodule

// File: rtl/bypass_data_mux.sv
module bypass_data_mux
    import bypass_pkg::*;
(
    input  path_t             path,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] alu_result,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] opnd_out
);

    always_comb begin
        unique case (path)
            ALU_PATH: opnd_out = alu_result;
            WB_PATH:  opnd_out = wb_data;
            default:  opnd_out = rf_rdata;
        endcase
    end

endmodule

// File: rtl/operand_bypass_sel.sv
module operand_bypass_sel
    import bypass_pkg::*;
#(
    parameter int SRC_SEL = 0
) (
    input  logic [5:0]  rf_op,
    input  logic [4:0]  rf_src,
    input  logic [5:0]  alu_op,
    input  logic [4:0]  alu_dest,
    input  logic        alu_valid,
    input  logic        wb_we,
    input  logic [4:0]  wb_addr,
    input  logic [31:0] rf_rdata,
    input  logic [31:0] alu_result,
    input  logic [31:0] wb_data,
    output logic [31:0] opnd_out
);

    logic  reads_src;
    path_t path;

    bypass_src_decode #(.SRC_SEL(SRC_SEL)) u_decode (
        .op        (rf_op),
        .reads_src (reads_src)
    );

    bypass_path_select u_path (
        .reads_src (reads_src),
        .rf_src    (rf_src),
        .alu_op    (alu_op),
        .alu_dest  (alu_dest),
        .alu_valid (alu_valid),
        .wb_we     (wb_we),
        .wb_addr   (wb_addr),
        .path      (path)
    );

    bypass_data_mux u_mux (
        .path       (path),
        .rf_rdata   (rf_rdata),
        .alu_result (alu_result),
        .wb_data    (wb_data),
        .opnd_out   (opnd_out)
    );

endmodule

// File: rtl/operand_bypass_sel_chk.sv
module operand_bypass_sel_chk (
    input logic [5:0]  rf_op,
    input logic [4:0]  rf_src,
    input logic [5:0]  alu_op,
    input logic [4:0]  alu_dest,
    input logic        alu_valid,
    input logic        wb_we,
    input logic [4:0]  wb_addr,
    input logic [31:0] rf_rdata,
    input logic [31:0] alu_result,
    input logic [31:0] wb_data,
    input logic [31:0] opnd_out
);

    always_comb begin
        // R1
        out_is_candidate_chk: assert (opnd_out == rf_rdata || opnd_out == alu_result
                                      || opnd_out == wb_data);
        // R7
        zero_reg_chk: assert (rf_src != 5'd31 || opnd_out == rf_rdata);
        // R8
        if (!alu_valid && !wb_we)
            bubble_ignored_chk: assert (opnd_out == rf_rdata);
        // R9
        if (!alu_op[5] && !wb_we)
            nonalu_ignored_chk: assert (opnd_out == rf_rdata);
        // R3
        if (rf_op[5:4] == 2'b00)
            noread_chk: assert (opnd_out == rf_rdata);
        // R6
        if (rf_op[5:4] == 2'b10 && alu_valid && alu_op[5] && rf_src == alu_dest
            && rf_src != 5'd31)
            alu_priority_chk: assert (opnd_out == alu_result);
    end

endmodule

bind operand_bypass_sel operand_bypass_sel_chk u_chk (
    .rf_op      (rf_op),
    .rf_src     (rf_src),
    .alu_op     (alu_op),
    .alu_dest   (alu_dest),
    .alu_valid  (alu_valid),
    .wb_we      (wb_we),
    .wb_addr    (wb_addr),
    .rf_rdata   (rf_rdata),
    .alu_result (alu_result),
    .wb_data    (wb_data),
    .opnd_out   (opnd_out)
);

// File: tb/operand_bypass_sel_test.sv
module operand_bypass_sel_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic [5:0]  rf_op = '0, alu_op = '0;
    logic [4:0]  rf_src = '0, alu_dest = '0, wb_addr = '0;
    logic        alu_valid = 1'b0, wb_we = 1'b0;
    logic [31:0] rf_rdata = '0, alu_result = '0, wb_data = '0;
    logic [31:0] out_a, out_b;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    operand_bypass_sel #(.SRC_SEL(0)) uut (
        .rf_op(rf_op), .rf_src(rf_src), .alu_op(alu_op), .alu_dest(alu_dest),
        .alu_valid(alu_valid), .wb_we(wb_we), .wb_addr(wb_addr),
        .rf_rdata(rf_rdata), .alu_result(alu_result), .wb_data(wb_data),
        .opnd_out(out_a));

    operand_bypass_sel #(.SRC_SEL(1)) uut_b (
        .rf_op(rf_op), .rf_src(rf_src), .alu_op(alu_op), .alu_dest(alu_dest),
        .alu_valid(alu_valid), .wb_we(wb_we), .wb_addr(wb_addr),
        .rf_rdata(rf_rdata), .alu_result(alu_result), .wb_data(wb_data),
        .opnd_out(out_b));

    // R2, R3: operand read tables
    function automatic bit model_reads(input logic [5:0] op, input int which);
        int lo = int'(op[3:0]);
        if (which == 1) return op[5:4] == 2'b10;
        if (op[5]) return 1;
        if (op[5:4] == 2'b01)
            return lo == 0 || lo == 1 || lo == 3 || lo == 4 || lo == 5;
        return 0;
    endfunction

    // R1, R4-R9
    function automatic logic [31:0] model_out(input int which);
        if (!model_reads(rf_op, which) || rf_src == 5'd31) return rf_rdata;
        if (alu_valid && alu_op[5] && alu_dest == rf_src) return alu_result;
        if (wb_we && wb_addr == rf_src) return wb_data;
        return rf_rdata;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] rop, input logic [4:0] src,
                         input logic [5:0] aop, input logic [4:0] ad, input logic av,
                         input logic we, input logic [4:0] wa);
        @(negedge clk);
        rf_op = rop; rf_src = src; alu_op = aop; alu_dest = ad; alu_valid = av;
        wb_we = we; wb_addr = wa;
        rf_rdata = 32'h1111_1111; alu_result = 32'hAAAA_AAAA; wb_data = 32'hBBBB_BBBB;
        #2;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2;
        check("R1 idle", out_a, 32'h0);
        // R1: no match
        apply(6'h20, 5'd3, 6'h20, 5'd4, 1, 1, 5'd5);
        check("R1", out_a, 32'h1111_1111);
        // R4: ALU forward, constant-class producer
        apply(6'h20, 5'd3, 6'h30, 5'd3, 1, 0, 5'd0);
        check("R4", out_a, 32'hAAAA_AAAA);
        // R5: write-back forward
        apply(6'h20, 5'd3, 6'h20, 5'd4, 1, 1, 5'd3);
        check("R5", out_a, 32'hBBBB_BBBB);
        check("R5 operand B", out_b, 32'hBBBB_BBBB);
        // R6: both match, ALU wins
        apply(6'h20, 5'd7, 6'h21, 5'd7, 1, 1, 5'd7);
        check("R6", out_a, 32'hAAAA_AAAA);
        // R7: register 31 never forwarded
        apply(6'h20, 5'd31, 6'h20, 5'd31, 1, 1, 5'd31);
        check("R7", out_a, 32'h1111_1111);
        check("R7 operand B", out_b, 32'h1111_1111);
        // R8: bubble in ALU stage, write-back decides
        apply(6'h20, 5'd9, 6'h20, 5'd9, 0, 1, 5'd9);
        check("R8", out_a, 32'hBBBB_BBBB);
        apply(6'h20, 5'd9, 6'h20, 5'd9, 0, 0, 5'd9);
        check("R8 no wb", out_a, 32'h1111_1111);
        // R9: load in ALU stage is not forwarded
        apply(6'h20, 5'd2, 6'h10, 5'd2, 1, 0, 5'd0);
        check("R9", out_a, 32'h1111_1111);
        // R2: branch reads A; pc-load (4'hF) reads nothing
        apply(6'h14, 5'd2, 6'h20, 5'd2, 1, 0, 5'd0);
        check("R2 branch", out_a, 32'hAAAA_AAAA);
        apply(6'h1F, 5'd2, 6'h20, 5'd2, 1, 1, 5'd2);
        check("R2 pcload", out_a, 32'h1111_1111);
        // R3: constant-class does not read B
        apply(6'h30, 5'd2, 6'h20, 5'd2, 1, 1, 5'd2);
        check("R3 A", out_a, 32'hAAAA_AAAA);
        check("R3 B", out_b, 32'h1111_1111);
        apply(6'h05, 5'd2, 6'h20, 5'd2, 1, 1, 5'd2);
        check("R3 class0", out_a, 32'h1111_1111);

        // random pass against the reference model, every clock
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rf_op      = 6'($urandom);
            alu_op     = 6'($urandom);
            rf_src     = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 4);
            alu_dest   = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 4);
            wb_addr    = ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 4);
            alu_valid  = 1'($urandom);
            wb_we      = 1'($urandom);
            rf_rdata   = $urandom;
            alu_result = $urandom;
            wb_data    = $urandom;
            #2;
            check("R1-model A (R4 R5 R6 R7 R8 R9)", out_a, model_out(0));
            check("R3-model B", out_b, model_out(1));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule